// File: doc/BRIEF.md
# Normalised Beam Position Feedback Corrector

This block sits inside a bunch-by-bunch feedback loop. Each bunch yields a signed difference sample and a signed sum sample from a position pickup. The block divides the difference by the sum, which makes the reading independent of bunch charge. It does this by multiplying the difference by a reciprocal that a table returns for the sum's magnitude. It then scales the result by a selectable power of two and adds the correction it issued for the previous bunch. The result goes to a DAC word that drives the kicker.

The DAC word keeps its value for a fixed number of clock cycles, set to about one bunch spacing. After that it returns to zero. A train-start pulse clears the accumulated loop term before a new bunch train arrives. Gain scaling is a left shift and adds no pipeline stage. Any excess beyond the output width wraps around and is not clamped. The whole path from sample to DAC takes five clock edges, which is within the eight-cycle budget.

Top module: `pos_fb_corrector`

## Requirements
- R1: After reset, `dac_out` is 0 and both `dac_update` and `dac_active` are low.
- R2: A sample taken with `sample_valid` high at a clock edge produces a one-cycle `dac_update` pulse, and a new `dac_out` value, at the fifth rising edge counted from that edge, inclusive. This is within 8 cycles.
- R3: The normalised position is bits [29:14] of the signed product `diff_in * recip`. Here `recip` is an unsigned 16-bit value from a 256-entry table. The table is indexed by bits [13:6] of the 14-bit magnitude of `sum_in`. Entry i holds floor(65535 / i), and entry 0 holds 65535.
- R4: `gain_sel` (0 to 7) is captured together with its sample. The position is multiplied by 2^gain_sel through a left shift.
- R5: Bits shifted above bit 15 are discarded. The 16-bit two's-complement result wraps and is never saturated. The same applies to the loop addition.
- R6: Each correction equals the gained position plus the previous correction, modulo 2^16.
- R7: A `train_start` pulse clears the loop term. The next correction then equals its gained position alone.
- R8: After an update, `dac_out` keeps the new value and `dac_active` stays high for HOLD_CYCLES (default 31) cycles. Then `dac_out` returns to 0 and `dac_active` falls.
- R9: With `sample_valid` low, changes on `diff_in`, `sum_in` and `gain_sel` cause no update. The held `dac_out` value stays the same.
- R10: An update that arrives while a value is being held loads the new value and restarts the full hold interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| train_start | input | 1 | Clears the loop term before a bunch train |
| sample_valid | input | 1 | Qualifies the current sample pair |
| diff_in | input | 14 | Signed difference sample |
| sum_in | input | 14 | Signed sum sample |
| gain_sel | input | 3 | Shift amount k, gain 2^k |
| dac_out | output | 16 | Signed correction word to the DAC |
| dac_update | output | 1 | One-cycle pulse when `dac_out` takes a new correction |
| dac_active | output | 1 | High while a correction is being held |

## Verification
The assertions assume that `train_start` is pulsed only while no sample is in flight in the pipeline. With that assumption, clearing the loop never coincides with a loop update. The stimulus waits for every pending correction to reach the DAC before it pulses `train_start`. It also holds `sample_valid` low for whole cycles between bunches. The inputs may change freely while `sample_valid` is low, and the stimulus deliberately changes them there to show that they are ignored.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // Reciprocal model: full-scale unsigned word divided by the table index
  function automatic logic [15:0] recip_of(input int idx);
    if (idx == 0) return 16'hFFFF;
    return 16'(65535 / idx);
  endfunction
endpackage

// File: rtl/fb_recip_rom.sv
module fb_recip_rom #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [0:DEPTH-1];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(fb_pkg::recip_of(i));
  end

  always_ff @(posedge clk) data <= mem[addr];
endmodule

// File: rtl/fb_norm_gain.sv
module fb_norm_gain #(
  parameter int SAMPLE_W = 14,
  parameter int RECIP_W  = 16,
  parameter int LUT_AW   = 8,
  parameter int GAIN_W   = 3,
  parameter int OUT_W    = 16,
  parameter int FRAC     = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid_in,
  input  logic [SAMPLE_W-1:0] diff_in,
  input  logic [SAMPLE_W-1:0] sum_in,
  input  logic [GAIN_W-1:0]   gain_in,
  output logic                valid_out,
  output logic [OUT_W-1:0]    gained_out
);
  localparam int PROD_W = SAMPLE_W + RECIP_W + 1;

  // stage 1: capture, magnitude of sum
  logic [SAMPLE_W-1:0] sum_mag;
  logic                v1, v2, v3;
  logic [SAMPLE_W-1:0] d1, d2;
  logic [GAIN_W-1:0]   g1, g2, g3;
  logic [LUT_AW-1:0]   idx1;
  logic [RECIP_W-1:0]  recip2;
  logic signed [PROD_W-1:0] prod3;
  logic [OUT_W-1:0]    pos3;

  always_comb sum_mag = sum_in[SAMPLE_W-1] ? (~sum_in + 1'b1) : sum_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; valid_out <= 1'b0;
    end else begin
      v1 <= valid_in; v2 <= v1; v3 <= v2; valid_out <= v3;
    end
  end

  always_ff @(posedge clk) begin
    d1   <= diff_in;
    g1   <= gain_in;
    idx1 <= sum_mag[SAMPLE_W-1 -: LUT_AW];
  end

  // stage 2: reciprocal lookup (registered read)
  fb_recip_rom #(.AW(LUT_AW), .DW(RECIP_W)) u_rom (
    .clk (clk),
    .addr(idx1),
    .data(recip2)
  );

  always_ff @(posedge clk) begin
    d2 <= d1;
    g2 <= g1;
  end

  // stage 3: signed x unsigned product
  always_ff @(posedge clk) begin
    prod3 <= PROD_W'($signed(d2)) * $signed({1'b0, recip2});
    g3    <= g2;
  end

  // stage 4: scale down and gain by shift, wrapping to OUT_W
  always_comb pos3 = prod3[FRAC +: OUT_W];

  always_ff @(posedge clk) gained_out <= pos3 << g3;

  p_pipe_latency_r2: assert property (@(posedge clk) disable iff (rst)
    valid_in |-> ##4 valid_out);
  p_pipe_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !v3 |=> !valid_out);
endmodule

// File: rtl/fb_dac_hold.sv
module fb_dac_hold #(
  parameter int OUT_W       = 16,
  parameter int HOLD_CYCLES = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             train_start,
  input  logic             valid_in,
  input  logic [OUT_W-1:0] gained_in,
  output logic [OUT_W-1:0] dac_out,
  output logic             dac_update,
  output logic             dac_active
);
  localparam int TW = $clog2(HOLD_CYCLES + 1);
  localparam logic [TW-1:0] HOLD_T = TW'(HOLD_CYCLES);

  logic [OUT_W-1:0] loop_q;
  logic [OUT_W-1:0] corr;
  logic [TW-1:0]    timer_q;

  always_comb corr = gained_in + loop_q;

  always_ff @(posedge clk) begin
    if (rst || train_start) loop_q <= '0;
    else if (valid_in)      loop_q <= corr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_out    <= '0;
      timer_q    <= '0;
      dac_update <= 1'b0;
    end else begin
      dac_update <= valid_in;
      if (valid_in) begin
        dac_out <= corr;
        timer_q <= HOLD_T;
      end else if (timer_q != '0) begin
        timer_q <= timer_q - 1'b1;
        if (timer_q == TW'(1)) dac_out <= '0;
      end
    end
  end

  always_comb dac_active = (timer_q != '0);

  p_loop_clear_r7: assert property (@(posedge clk) disable iff (rst)
    train_start |=> loop_q == '0);
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !dac_active |-> dac_out == '0);
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (!valid_in && timer_q > TW'(1)) |=> $stable(dac_out));
  p_timer_bound_r10: assert property (@(posedge clk) disable iff (rst)
    timer_q <= HOLD_T);
  p_update_active_r8: assert property (@(posedge clk) disable iff (rst)
    dac_update |-> dac_active);
endmodule

// File: rtl/pos_fb_corrector.sv
module pos_fb_corrector #(
  parameter int SAMPLE_W    = 14,
  parameter int RECIP_W     = 16,
  parameter int LUT_AW      = 8,
  parameter int GAIN_W      = 3,
  parameter int OUT_W       = 16,
  parameter int FRAC        = 14,
  parameter int HOLD_CYCLES = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                train_start,
  input  logic                sample_valid,
  input  logic [SAMPLE_W-1:0] diff_in,
  input  logic [SAMPLE_W-1:0] sum_in,
  input  logic [GAIN_W-1:0]   gain_sel,
  output logic [OUT_W-1:0]    dac_out,
  output logic                dac_update,
  output logic                dac_active
);
  logic             ng_valid;
  logic [OUT_W-1:0] ng_gained;

  fb_norm_gain #(
    .SAMPLE_W(SAMPLE_W), .RECIP_W(RECIP_W), .LUT_AW(LUT_AW),
    .GAIN_W(GAIN_W), .OUT_W(OUT_W), .FRAC(FRAC)
  ) u_norm (
    .clk       (clk),
    .rst       (rst),
    .valid_in  (sample_valid),
    .diff_in   (diff_in),
    .sum_in    (sum_in),
    .gain_in   (gain_sel),
    .valid_out (ng_valid),
    .gained_out(ng_gained)
  );

  fb_dac_hold #(.OUT_W(OUT_W), .HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .train_start(train_start),
    .valid_in   (ng_valid),
    .gained_in  (ng_gained),
    .dac_out    (dac_out),
    .dac_update (dac_update),
    .dac_active (dac_active)
  );

  p_update_latency_r2: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> ##5 dac_update);
endmodule

// File: tb/pos_fb_corrector_test.sv
module pos_fb_corrector_test;
  localparam int HOLD = 31;
  localparam int LAT  = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        train_start = 1'b0;
  logic        sample_valid = 1'b0;
  logic [13:0] diff_in = '0;
  logic [13:0] sum_in = '0;
  logic [2:0]  gain_sel = '0;
  logic [15:0] dac_out;
  logic        dac_update;
  logic        dac_active;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] exp_loop = '0;
  logic [15:0] exp_q[$];
  int          stamp_q[$];
  string       tag_q[$];

  pos_fb_corrector #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst), .train_start(train_start), .sample_valid(sample_valid),
    .diff_in(diff_in), .sum_in(sum_in), .gain_sel(gain_sel),
    .dac_out(dac_out), .dac_update(dac_update), .dac_active(dac_active)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // independent model of R3/R4/R5
  function automatic logic [15:0] model_gain(input int d, input int s, input int k);
    int mag, idx, r;
    longint p, pos;
    mag = (s < 0) ? -s : s;
    idx = (mag >> 6) & 255;
    r = (idx == 0) ? 65535 : 65535 / idx;
    p = longint'(d) * longint'(r);
    pos = p >>> 14;
    return 16'(16'(pos) << k);
  endfunction

  task automatic send(input int d, input int s, input int k, input string tag,
                      output logic [15:0] expv);
    @(negedge clk);
    diff_in = 14'(d); sum_in = 14'(s); gain_sel = 3'(k); sample_valid = 1'b1;
    expv = model_gain(d, s, k) + exp_loop;
    exp_loop = expv;
    exp_q.push_back(expv); stamp_q.push_back(cyc); tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      sample_valid = 1'b0;
      diff_in = diff_in + 14'd97; sum_in = sum_in ^ 14'h155; gain_sel = gain_sel + 3'd1;
    end
  endtask

  task automatic drain();
    while (exp_q.size() != 0) idle(1);
    idle(1);
  endtask

  task automatic wait_update();
    do @(negedge clk); while (!dac_update);
  endtask

  // starts at the negedge where dac_update is seen; R8/R9 at ports
  task automatic watch_hold(input logic [15:0] expv, input string req);
    for (int i = 1; i < HOLD; i++) begin
      @(negedge clk);
      sample_valid = 1'b0;
      diff_in = diff_in + 14'd311; sum_in = ~sum_in;
      if (dac_out != expv || !dac_active) begin
        check(1'b0, req, int'(dac_out), int'(expv));
        return;
      end
    end
    check(1'b1, req, 0, 0);
    @(negedge clk);
    check(dac_out == 16'd0 && !dac_active, "R8 release", int'(dac_out), 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && dac_update) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9 unexpected update", int'(dac_out), 0);
      end else begin
        logic [15:0] e;
        int st;
        string t;
        e = exp_q.pop_front(); st = stamp_q.pop_front(); t = tag_q.pop_front();
        check(dac_out === e, t, int'($signed(dac_out)), int'($signed(e)));
        check(cyc - st == LAT, "R2 latency", cyc - st, LAT);
      end
    end
  end

  initial begin
    #400000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(dac_out == 0 && !dac_update && !dac_active, "R1 reset", int'(dac_out), 0);

    // R3/R4 various patterns, loop off by train start each time
    exp_loop = '0;
    send(1000, 8000, 0, "R3 large sum", v);
    idle(1); drain();
    @(negedge clk); train_start = 1'b1; exp_loop = '0;
    @(negedge clk); train_start = 1'b0;
    send(-1500, -3000, 3, "R4 gain 8 negative", v);
    idle(1); drain();
    @(negedge clk); train_start = 1'b1; exp_loop = '0;
    @(negedge clk); train_start = 1'b0;
    send(200, 40, 7, "R3 small sum index 0 gain 128", v);
    idle(1); drain();

    // R7 train start clears loop
    @(negedge clk); train_start = 1'b1; exp_loop = '0;
    @(negedge clk); train_start = 1'b0;
    send(4000, 100, 3, "R5 wrap after shift", v);
    idle(1); drain();
    @(negedge clk); train_start = 1'b1; exp_loop = '0;
    @(negedge clk); train_start = 1'b0;
    send(-8192, -8192, 1, "R7 first after train start", v);
    // R6 back-to-back accumulation, includes wrap on the add
    send(3000, 500, 2, "R6 accumulate 1", v);
    send(-2000, 1200, 5, "R6 accumulate 2", v);
    send(8191, 64, 6, "R6 R5 accumulate wrap", v);
    idle(2); drain();

    // R8/R9 hold and ignore with valid low
    @(negedge clk); train_start = 1'b1; exp_loop = '0;
    @(negedge clk); train_start = 1'b0;
    send(2500, 2000, 2, "R8 hold value", v);
    sample_valid = 1'b1;
    idle(1);
    wait_update();
    watch_hold(v, "R9 held value unchanged");
    idle(3);
    check(exp_q.size() == 0 && !dac_active, "R9 no stray update", exp_q.size(), 0);

    // R10 retrigger during hold
    send(700, 900, 4, "R10 first", v);
    idle(1);
    wait_update();
    idle(10);
    send(-900, 1800, 1, "R10 second", v);
    idle(1);
    wait_update();
    watch_hold(v, "R10 hold restarted");
    idle(3);

    check(exp_q.size() == 0, "R2 all drained", exp_q.size(), 0);
    finish_run();
  end
endmodule